// File: doc/BRIEF.md
# Toggle-Encoded Busy Link Controller

This block carries a busy (stop-acquisition) level across a single AC-coupled wire. A static level cannot cross the coupling capacitor, so the block sends busy as continuous activity. The transmit half turns a busy level into a line that inverts at a fixed interval for as long as busy holds. The receive half watches an inbound line for transitions and rebuilds a level from them. That level stays set while transitions keep arriving and clears after a quiet interval.

The outbound fast line has more than one use, and a two-bit mode input chooses which one applies. In triggered operation the line is a direct, unregistered copy of an asynchronous trigger input. In auto operation it carries the local busy in toggle form. In burst operation it carries the local busy OR'd with any busy recovered from the front ends, so that one busy front end stops acquisition across the whole detector. A fourth mode code parks the line low. Fast signalling has a dedicated wire and shares no logic with the fixed-latency command path.

Top module: `busy_link_ctrl`

## Requirements
- R1: During reset and after reset is released, `busy_rx` is 0. `fast_out` is 0 in every mode except triggered mode.
- R2: With `mode` = 2'b00 (triggered), `fast_out` equals `trig_in` in the same cycle through combinational logic only. `busy_local` and `fast_in` have no effect on it.
- R3: With `mode` = 2'b01 (auto), suppose `busy_local` is sampled high on L consecutive rising edges after being low. Then `fast_out` inverts on the HALF_PERIOD-th of those edges and on every HALF_PERIOD-th edge after it, giving floor(L/HALF_PERIOD) inversions in total.
- R4: In auto or burst mode, `fast_out` holds its level on every edge where the busy being encoded is sampled low.
- R5: A transition on `fast_in` before rising edge k sets `busy_rx` after edge k+2. This latency comes from a two-stage synchronizer plus one stage of edge detection.
- R6: `busy_rx` clears at the TIMEOUT-th rising edge after the last edge that set or refreshed it, unless another transition refreshes it on that edge. Transitions spaced at most TIMEOUT cycles apart therefore keep it set without a gap.
- R7: With `mode` = 2'b10 (burst), the encoded busy is `busy_local` OR `busy_rx`. A single inbound transition with `busy_local` low produces floor(TIMEOUT/HALF_PERIOD) outbound inversions.
- R8: In auto mode, `busy_rx` does not influence `fast_out`, but `busy_rx` still reports inbound activity.
- R9: With `mode` = 2'b11 (parked), `fast_out` is 0 whatever the other inputs do.
- R10: In auto and burst modes, `trig_in` has no effect on `fast_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode | input | 2 | 00 triggered, 01 auto, 10 burst, 11 parked |
| busy_local | input | 1 | Local busy level to encode |
| trig_in | input | 1 | Asynchronous trigger, forwarded in triggered mode |
| fast_in | input | 1 | Inbound toggle-encoded busy line (asynchronous) |
| fast_out | output | 1 | Outbound fast line |
| busy_rx | output | 1 | Busy level recovered from `fast_in` |

## Verification
On every cycle, the assertions check four things. First, the recovered busy agrees with an independent count of cycles since the last detected transition. Second, it only rises after such a transition. Third, the auto-mode line never moves while the encoded busy is low. Fourth, with a half period of two or more, it never inverts on two adjacent edges. Only the bench scenarios can show the exact inversion counts and first-inversion position for each busy length, the receive latency, and the merging of gap lengths around the timeout. They also cover the burst-mode relay and the pass-through and parked behaviour of the mode mux.

// File: rtl/busy_link_pkg.sv
package busy_link_pkg;

  typedef enum logic [1:0] {
    LM_TRIG  = 2'b00,
    LM_AUTO  = 2'b01,
    LM_BURST = 2'b10,
    LM_PARK  = 2'b11
  } link_mode_e;

endpackage

// File: rtl/busy_link_rst_sync.sv
module busy_link_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/busy_link_bit_sync.sv
module busy_link_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic stage_d;
      if (g == 0) begin : g_first
        always_comb stage_d = d_i;
      end else begin : g_rest
        always_comb stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/busy_link_toggle_tx.sv
module busy_link_toggle_tx #(
  parameter int HALF_PERIOD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  output logic line_o
);

  localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          line_q, line_d;

  always_comb begin
    cnt_d  = cnt_q;
    line_d = line_q;
    if (!busy_i) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d  = '0;
      line_d = ~line_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      line_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      line_q <= line_d;
    end
  end

  assign line_o = line_q;

endmodule

// File: rtl/busy_link_toggle_rx.sv
module busy_link_toggle_rx #(
  parameter int TIMEOUT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic busy_o,
  output logic edge_o
);

  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT - 1);

  logic          line_s;
  logic          prev_q;
  logic          seen_edge;
  logic          busy_q, busy_d;
  logic [TW-1:0] idle_q, idle_d;

  busy_link_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  always_comb seen_edge = line_s ^ prev_q;

  always_comb begin
    busy_d = busy_q;
    idle_d = idle_q;
    if (seen_edge) begin
      busy_d = 1'b1;
      idle_d = '0;
    end else if (busy_q) begin
      if (idle_q == LIMIT) begin
        busy_d = 1'b0;
        idle_d = '0;
      end else begin
        idle_d = idle_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      busy_q <= 1'b0;
      idle_q <= '0;
    end else begin
      prev_q <= line_s;
      busy_q <= busy_d;
      idle_q <= idle_d;
    end
  end

  assign busy_o = busy_q;
  assign edge_o = seen_edge;

endmodule

// File: rtl/busy_link_ctrl.sv
module busy_link_ctrl #(
  parameter int HALF_PERIOD = 2,
  parameter int TIMEOUT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       busy_local,
  input  logic       trig_in,
  input  logic       fast_in,
  output logic       fast_out,
  output logic       busy_rx
);
  import busy_link_pkg::*;

  logic       rst_sync_n;
  logic       tx_line;
  logic       rx_busy;
  logic       rx_edge;
  logic       enc_busy;
  link_mode_e mode_e;

  always_comb mode_e = link_mode_e'(mode);

  busy_link_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    case (mode_e)
      LM_AUTO:  enc_busy = busy_local;
      LM_BURST: enc_busy = busy_local | rx_busy;
      default:  enc_busy = 1'b0;
    endcase
  end

  busy_link_toggle_tx #(.HALF_PERIOD(HALF_PERIOD)) u_tx (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .busy_i (enc_busy),
    .line_o (tx_line)
  );

  busy_link_toggle_rx #(.TIMEOUT(TIMEOUT), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .line_i (fast_in),
    .busy_o (rx_busy),
    .edge_o (rx_edge)
  );

  always_comb begin
    case (mode_e)
      LM_TRIG:  fast_out = trig_in;
      LM_AUTO:  fast_out = tx_line;
      LM_BURST: fast_out = tx_line;
      default:  fast_out = 1'b0;
    endcase
  end

  assign busy_rx = rx_busy;

endmodule

// File: rtl/busy_link_checker.sv
module busy_link_checker #(
  parameter int HALF_PERIOD = 2,
  parameter int TIMEOUT     = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       busy_local,
  input logic       fast_out,
  input logic       busy_rx,
  input logic       rx_edge
);

  localparam int QW = $clog2(TIMEOUT + 1);
  localparam logic [QW-1:0] QMAX = QW'(TIMEOUT);

  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              quiet_q <= QMAX;
    else if (rx_edge)        quiet_q <= '0;
    else if (quiet_q < QMAX) quiet_q <= quiet_q + QW'(1);
  end

  // R1: recovered busy and encoded line quiet while reset holds
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!busy_rx && (mode == 2'b00 || !fast_out));
    end
  end

  // R6: recovered busy set exactly while fewer than TIMEOUT quiet cycles
  a_r6_timeout_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy_rx == (quiet_q < QMAX));

  // R5: a rise of busy_rx needs a detected transition one edge before
  a_r5_rise_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_rx) |-> $past(rx_edge));

  // R4: in auto mode the line is frozen on edges with busy low
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && $past(mode) == 2'b01 && !$past(busy_local))
      |-> $stable(fast_out));

  generate
    if (HALF_PERIOD >= 2) begin : g_spacing
      // R3: inversions never on adjacent edges in auto mode
      a_r3_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && $past(mode) == 2'b01 && !$stable(fast_out))
          |=> (mode != 2'b01 || $past(mode) != 2'b01 || $stable(fast_out)));
    end
  endgenerate

endmodule

bind busy_link_ctrl busy_link_checker #(
  .HALF_PERIOD (HALF_PERIOD),
  .TIMEOUT     (TIMEOUT)
) u_busy_link_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .mode       (mode),
  .busy_local (busy_local),
  .fast_out   (fast_out),
  .busy_rx    (busy_rx),
  .rx_edge    (rx_edge)
);

// File: tb/busy_link_ctrl_bench.sv
module busy_link_ctrl_bench;

  localparam int HP  = 2;
  localparam int TMO = 8;

  logic       clk;
  logic       rst_n;
  logic [1:0] mode;
  logic       busy_local;
  logic       trig_in;
  logic       fast_in;
  logic       fast_out;
  logic       busy_rx;

  int n_checks;
  int n_fail;
  bit reported;

  busy_link_ctrl #(.HALF_PERIOD(HP), .TIMEOUT(TMO), .SYNC_STAGES(2)) u_busy_link_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .busy_local (busy_local),
    .trig_in    (trig_in),
    .fast_in    (fast_in),
    .fast_out   (fast_out),
    .busy_rx    (busy_rx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R3 / R4: busy held L cycles in the current mode, count line inversions
  task automatic run_busy(input int len, input string req);
    int changes;
    int after;
    int first_idx;
    logic prev;
    repeat (4) step();
    prev = fast_out;
    changes = 0;
    after = 0;
    first_idx = -1;
    busy_local = 1'b1;
    for (int i = 0; i < len; i++) begin
      step();
      if (fast_out != prev) begin
        if (first_idx < 0) first_idx = i;
        changes++;
      end
      prev = fast_out;
    end
    busy_local = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step();
      if (fast_out != prev) after++;
      prev = fast_out;
    end
    check(changes == len / HP, req, changes, len / HP);
    if (len >= HP) check(first_idx == HP - 1, "R3 first inversion", first_idx, HP - 1);
    check(after == 0, "R4 hold after busy drop", after, 0);
  endtask

  // R5 / R6: two inbound transitions gap cycles apart
  task automatic run_gap(input int gap);
    int highs;
    int rises;
    int out_moves;
    logic prev_b;
    logic prev_o;
    int exp_h;
    int exp_r;
    highs = 0;
    rises = 0;
    out_moves = 0;
    prev_b = busy_rx;
    prev_o = fast_out;
    for (int i = 0; i < gap + 2 * TMO + 6; i++) begin
      if (i == 0 || i == gap) fast_in = ~fast_in;
      step();
      if (busy_rx) highs++;
      if (busy_rx && !prev_b) rises++;
      if (i == 1) check(busy_rx == 1'b0, "R5 not yet set", busy_rx, 0);
      if (i == 2) check(busy_rx == 1'b1, "R5 set latency", busy_rx, 1);
      if (fast_out != prev_o) out_moves++;
      prev_b = busy_rx;
      prev_o = fast_out;
    end
    exp_h = (gap <= TMO) ? gap + TMO : 2 * TMO;
    exp_r = (gap <= TMO) ? 1 : 2;
    check(highs == exp_h, "R6 busy duration", highs, exp_h);
    check(rises == exp_r, "R6 busy pulses", rises, exp_r);
    check(out_moves == 0, "R8 auto ignores busy_rx", out_moves, 0);
  endtask

  initial begin
    reported = 1'b0;
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int moves;
    logic prev;
    n_checks = 0;
    n_fail = 0;
    rst_n = 1'b0;
    mode = 2'b01;
    busy_local = 1'b0;
    trig_in = 1'b0;
    fast_in = 1'b0;
    repeat (3) step();
    check(busy_rx == 1'b0, "R1 busy_rx in reset", busy_rx, 0);
    check(fast_out == 1'b0, "R1 fast_out in reset", fast_out, 0);
    rst_n = 1'b1;
    repeat (4) step();
    check(busy_rx == 1'b0, "R1 busy_rx after reset", busy_rx, 0);
    check(fast_out == 1'b0, "R1 fast_out after reset", fast_out, 0);

    // R2 triggered pass-through, other inputs ignored
    mode = 2'b00;
    for (int p = 0; p < 8; p++) begin
      trig_in = p[0];
      busy_local = p[1];
      fast_in = p[2];
      #1;
      check(fast_out == trig_in, "R2 pass-through", fast_out, trig_in);
      step();
      check(fast_out == trig_in, "R2 held across edge", fast_out, trig_in);
    end
    busy_local = 1'b0;
    fast_in = 1'b0;
    trig_in = 1'b0;
    repeat (TMO + 6) step();

    // R9 parked mode
    mode = 2'b11;
    for (int p = 0; p < 4; p++) begin
      trig_in = p[0];
      busy_local = p[1];
      step();
      check(fast_out == 1'b0, "R9 parked low", fast_out, 0);
    end
    busy_local = 1'b0;
    trig_in = 1'b0;

    // R3 / R4 sweep in auto mode
    mode = 2'b01;
    for (int len = 0; len <= 12; len++) run_busy(len, "R3 auto inversions");

    // R10 trigger ignored in auto and burst
    for (int m = 1; m <= 2; m++) begin
      mode = m[1:0];
      repeat (2) step();
      prev = fast_out;
      moves = 0;
      for (int i = 0; i < 10; i++) begin
        trig_in = ~trig_in;
        step();
        if (fast_out != prev) moves++;
        prev = fast_out;
      end
      trig_in = 1'b0;
      check(moves == 0, "R10 trig ignored", moves, 0);
    end

    // R5 / R6 / R8 gap sweep in auto mode
    mode = 2'b01;
    for (int gap = 1; gap <= 12; gap++) begin
      run_gap(gap);
      repeat (4) step();
    end

    // R6 continuous activity keeps busy set
    moves = 0;
    for (int i = 0; i < 48; i++) begin
      if (i % TMO == 0) fast_in = ~fast_in;
      step();
      if (i >= 2 && !busy_rx) moves++;
    end
    check(moves == 0, "R6 steady toggling", moves, 0);
    repeat (TMO + 6) step();
    check(busy_rx == 1'b0, "R6 cleared after quiet", busy_rx, 0);

    // R7 burst relay of a recovered busy
    mode = 2'b10;
    repeat (4) step();
    prev = fast_out;
    moves = 0;
    fast_in = ~fast_in;
    for (int i = 0; i < TMO + 12; i++) begin
      step();
      if (fast_out != prev) moves++;
      prev = fast_out;
    end
    check(moves == TMO / HP, "R7 burst relay count", moves, TMO / HP);
    repeat (4) step();
    prev = fast_out;
    moves = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (fast_out != prev) moves++;
      prev = fast_out;
    end
    check(moves == 0, "R4 burst quiet", moves, 0);
    for (int len = 3; len <= 7; len += 2) run_busy(len, "R7 burst local busy");

    // R8 auto mode with the same inbound transition: no outbound motion
    mode = 2'b01;
    repeat (4) step();
    prev = fast_out;
    moves = 0;
    fast_in = ~fast_in;
    for (int i = 0; i < TMO + 12; i++) begin
      step();
      if (fast_out != prev) moves++;
      prev = fast_out;
    end
    check(moves == 0, "R8 auto no relay", moves, 0);

    report();
    $finish;
  end

endmodule